// File: doc/BRIEF.md
# Serial Display-Panel Initialization Sequencer

This block brings a display panel up and down over a three-wire serial link: an active-low select, a serial clock and a serial data line. A one-cycle power-on request makes it play a fixed script of twelve register writes taken from an internal constant table. A power-off request makes it send a single shutdown write. Each write is a 16-bit frame with the panel register address in the upper byte and the value in the lower byte. Bits go out most significant first.

All serial timing comes from one half-period length, `HALF_CYC`, counted in system clock cycles. The default suits a slow serial clock of about 25 µs per half-period at 125 MHz. Between frames the block keeps the select line high for a fixed number of half-periods. The first power-on write gets a longer pause. A build option, `ADDR_ENC`, sends the address field in an encoded form and lengthens every pause. The sequencer raises `busy` while it works and pulses `done` when the last frame has finished.

Top module: `panel_init_seq`

## Requirements
- R1: While reset is high and in the cycle after it: `lcd_en_n`=1, `lcd_sclk`=1, `lcd_sdat`=0, `busy`=0, `done`=0.
- R2: A frame carries 16 bits, first address[7:0] and then data[7:0], MSB first. Each bit holds `lcd_sdat` steady through that bit's whole low and high clock halves.
- R3: A frame opens with `lcd_en_n` going low while `lcd_sclk` is high and `lcd_sdat` is 0. This setup state lasts HALF_CYC cycles. `lcd_en_n` returns high in the cycle after the 16th bit's high half ends.
- R4: For each bit, `lcd_sclk` is low for HALF_CYC cycles and then high for HALF_CYC cycles, so the panel samples on the rising edge.
- R5: Power-on sends, in this order (address/data, hex): 05/1E, 05/5D, 0B/81, 01/95, 00/07, 06/15, 07/8D, 04/0F, 0D/3D, 10/42, 11/3A, 05/5F.
- R6: After each frame, `lcd_en_n` and `lcd_sclk` stay high and `lcd_sdat` stays 0 for a gap of 4×HALF_CYC cycles. The gap after the first power-on frame is 6×HALF_CYC. One more idle cycle follows the gap before the next frame's select falls.
- R7: Power-off sends the single frame 05/5E.
- R8: A request is taken in the cycle after it is sampled in idle, and `busy` then rises. If both requests arrive together, power-on wins. Requests that arrive while `busy` is high have no effect on the link or on `busy`.
- R9: `done` is high for exactly one cycle, in the cycle after the last frame's gap ends. `busy` is low in that same cycle.
- R10: With `ADDR_ENC`=1, the address byte sent is {address[5:0], 2'b10}, and every gap is 4×HALF_CYC cycles longer than in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_req | input | 1 | Request to play the power-on script |
| pwr_off_req | input | 1 | Request to send the shutdown write |
| busy | output | 1 | A script is in progress |
| done | output | 1 | One-cycle pulse when a script has finished |
| lcd_en_n | output | 1 | Active-low serial select |
| lcd_sclk | output | 1 | Serial clock, idles high |
| lcd_sdat | output | 1 | Serial data |

## Verification
The embedded properties assume a synchronous reset and `HALF_CYC` of at least 1. They make no assumption about how long a request is held, because any request that arrives during `busy` must be dropped.

The stimulus pulses requests for a single cycle. It sends a power-on request, then a power-off request, then both at once. Extra requests are fired while a run is busy. Each run is given time to reach `done` before the next one starts.

Two instances run side by side: one with plain addressing and one with encoded addressing. They use different short half-periods, so that a shared off-by-one in the timers shows up as a mismatch.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;

   localparam int BYTE_W      = 8;
   localparam int FRAME_W     = 2 * BYTE_W;
   localparam int IDX_W       = 4;
   localparam int ON_LAST     = 11;   // index of final power-on write
   localparam int OFF_IDX     = 12;   // index of the shutdown write
   localparam int BASE_GAP    = 4;    // half-periods after each frame
   localparam int FIRST_EXTRA = 2;    // extra half-periods after first write
   localparam int ENC_EXTRA   = 4;    // extra half-periods in encoded mode
   localparam int GAP_W       = 4;

   typedef struct packed {
      logic [BYTE_W-1:0] reg_addr;
      logic [BYTE_W-1:0] reg_val;
   } panel_wr_t;

   // constant script: entries 0..11 power-on, entry 12 power-off
   function automatic panel_wr_t script_entry(input logic [IDX_W-1:0] idx);
      panel_wr_t w;
      case (idx)
         4'd0:    w = '{8'h05, 8'h1E};
         4'd1:    w = '{8'h05, 8'h5D};
         4'd2:    w = '{8'h0B, 8'h81};
         4'd3:    w = '{8'h01, 8'h95};
         4'd4:    w = '{8'h00, 8'h07};
         4'd5:    w = '{8'h06, 8'h15};
         4'd6:    w = '{8'h07, 8'h8D};
         4'd7:    w = '{8'h04, 8'h0F};
         4'd8:    w = '{8'h0D, 8'h3D};
         4'd9:    w = '{8'h10, 8'h42};
         4'd10:   w = '{8'h11, 8'h3A};
         4'd11:   w = '{8'h05, 8'h5F};
         4'd12:   w = '{8'h05, 8'h5E};
         default: w = '{8'h00, 8'h00};
      endcase
      return w;
   endfunction

endpackage

// File: rtl/panel_script_rom.sv
module panel_script_rom
   import panel_init_pkg::*;
#(
   parameter bit ADDR_ENC = 1'b0
) (
   input  logic [IDX_W-1:0]   idx,
   output logic [FRAME_W-1:0] frame,
   output logic [GAP_W-1:0]   gap_halves
);

   panel_wr_t         entry;
   logic [GAP_W-1:0]  first_add;

   assign entry     = script_entry(idx);
   assign first_add = (idx == '0) ? GAP_W'(FIRST_EXTRA) : '0;

   generate
      if (ADDR_ENC) begin : g_enc
         assign frame      = {entry.reg_addr[BYTE_W-3:0], 2'b10, entry.reg_val};
         assign gap_halves = GAP_W'(BASE_GAP + ENC_EXTRA) + first_add;
      end else begin : g_plain
         assign frame      = {entry.reg_addr, entry.reg_val};
         assign gap_halves = GAP_W'(BASE_GAP) + first_add;
      end
   endgenerate

endmodule

// File: rtl/panel_frame_shifter.sv
module panel_frame_shifter #(
   parameter int HALF_CYC = 3125,
   parameter int FRAME_W  = 16,
   parameter int GAP_W    = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   input  logic [GAP_W-1:0]   gap_halves,
   output logic               en_n,
   output logic               sclk,
   output logic               sdat,
   output logic               fin
);

   localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam int BIT_W = $clog2(FRAME_W);

   typedef enum logic [2:0] {SH_IDLE, SH_SETUP, SH_LO, SH_HI, SH_GAP} sh_state_t;

   sh_state_t          state;
   logic [CNT_W-1:0]   cnt;
   logic               tick;
   logic [BIT_W-1:0]   bitn;
   logic [FRAME_W-1:0] shreg;
   logic [GAP_W-1:0]   gap_r;
   logic [GAP_W-1:0]   hcnt;

   assign tick = (cnt == CNT_W'(HALF_CYC - 1));
   assign fin  = (state == SH_GAP) && tick && (hcnt == gap_r - 1'b1);

   // half-period timer
   always_ff @(posedge clk) begin
      if (rst || state == SH_IDLE || tick) cnt <= '0;
      else                                 cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= SH_IDLE;
         en_n  <= 1'b1;
         sclk  <= 1'b1;
         sdat  <= 1'b0;
         bitn  <= '0;
         shreg <= '0;
         gap_r <= '0;
         hcnt  <= '0;
      end else begin
         case (state)
            SH_IDLE: if (start) begin
               state <= SH_SETUP;
               en_n  <= 1'b0;
               sdat  <= 1'b0;
               shreg <= frame;
               gap_r <= gap_halves;
            end
            SH_SETUP: if (tick) begin
               state <= SH_LO;
               sclk  <= 1'b0;
               sdat  <= shreg[FRAME_W-1];
               bitn  <= '0;
            end
            SH_LO: if (tick) begin
               state <= SH_HI;
               sclk  <= 1'b1;
            end
            SH_HI: if (tick) begin
               if (bitn == BIT_W'(FRAME_W - 1)) begin
                  state <= SH_GAP;
                  en_n  <= 1'b1;
                  sdat  <= 1'b0;
                  hcnt  <= '0;
               end else begin
                  state <= SH_LO;
                  sclk  <= 1'b0;
                  sdat  <= shreg[FRAME_W-2];
                  shreg <= shreg << 1;
                  bitn  <= bitn + 1'b1;
               end
            end
            SH_GAP: if (tick) begin
               if (fin) state <= SH_IDLE;
               else     hcnt  <= hcnt + 1'b1;
            end
            default: state <= SH_IDLE;
         endcase
      end
   end

   // select never moves while the clock is low (R3)
   assert_sel_clk_high_R3: assert property (@(posedge clk) disable iff (rst)
      ($fell(en_n) || $rose(en_n)) |-> sclk);

   // a frame opens with data low (R3)
   assert_open_data_low_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(en_n) |-> !sdat);

   // data holds while the clock is high inside a frame (R2)
   assert_data_stable_R2: assert property (@(posedge clk) disable iff (rst)
      (sclk && $past(sclk) && !en_n && !$past(en_n)) |-> $stable(sdat));

   // clock is parked high whenever the select is inactive (R4)
   assert_clk_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
      en_n |-> sclk);

   // a new frame never starts with an empty gap (R6)
   assert_gap_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
      (start && state == SH_IDLE) |-> (gap_halves != '0));

endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
   import panel_init_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             on_req,
   input  logic             off_req,
   input  logic             fin,
   output logic             start,
   output logic [IDX_W-1:0] idx,
   output logic             busy,
   output logic             done
);

   typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} sq_state_t;

   sq_state_t        state;
   logic [IDX_W-1:0] last_idx;

   assign start = (state == SQ_ISSUE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= SQ_IDLE;
         idx      <= '0;
         last_idx <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            SQ_IDLE: begin
               if (on_req) begin
                  idx      <= '0;
                  last_idx <= IDX_W'(ON_LAST);
                  state    <= SQ_ISSUE;
                  busy     <= 1'b1;
               end else if (off_req) begin
                  idx      <= IDX_W'(OFF_IDX);
                  last_idx <= IDX_W'(OFF_IDX);
                  state    <= SQ_ISSUE;
                  busy     <= 1'b1;
               end
            end
            SQ_ISSUE: state <= SQ_WAIT;
            SQ_WAIT: if (fin) begin
               if (idx == last_idx) begin
                  state <= SQ_IDLE;
                  busy  <= 1'b0;
                  done  <= 1'b1;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= SQ_ISSUE;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // done is a single-cycle pulse (R9)
   assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // done only with busy already dropped (R9)
   assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

   // busy holds while a frame is still in flight (R8)
   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (state == SQ_WAIT && !fin) |=> busy);

   // script index stays inside the table (R5)
   assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
      busy |-> (idx <= IDX_W'(OFF_IDX)));

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
   import panel_init_pkg::*;
#(
   parameter int HALF_CYC = 3125,
   parameter bit ADDR_ENC = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic pwr_on_req,
   input  logic pwr_off_req,
   output logic busy,
   output logic done,
   output logic lcd_en_n,
   output logic lcd_sclk,
   output logic lcd_sdat
);

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
      if (BASE_GAP + FIRST_EXTRA + ENC_EXTRA >= (1 << GAP_W)) begin : g_bad_gap
         $error("gap counter too narrow");
      end
   endgenerate

   logic               start;
   logic               fin;
   logic [IDX_W-1:0]   idx;
   logic [FRAME_W-1:0] frame;
   logic [GAP_W-1:0]   gap_halves;

   panel_seq_ctrl u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .on_req  (pwr_on_req),
      .off_req (pwr_off_req),
      .fin     (fin),
      .start   (start),
      .idx     (idx),
      .busy    (busy),
      .done    (done)
   );

   panel_script_rom #(.ADDR_ENC(ADDR_ENC)) u_rom (
      .idx        (idx),
      .frame      (frame),
      .gap_halves (gap_halves)
   );

   panel_frame_shifter #(
      .HALF_CYC (HALF_CYC),
      .FRAME_W  (FRAME_W),
      .GAP_W    (GAP_W)
   ) u_shift (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .frame      (frame),
      .gap_halves (gap_halves),
      .en_n       (lcd_en_n),
      .sclk       (lcd_sclk),
      .sdat       (lcd_sdat),
      .fin        (fin)
   );

   // link rests in its idle state whenever no script runs (R8)
   assert_idle_link_R8: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (lcd_en_n && lcd_sclk && !lcd_sdat));

   // select can only be active inside a busy window (R3)
   assert_sel_in_busy_R3: assert property (@(posedge clk) disable iff (rst)
      !lcd_en_n |-> busy);

endmodule

// File: tb/panel_init_seq_tb_top.sv
module panel_init_seq_tb_top;

   localparam int H0 = 3;
   localparam int H1 = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic on_req = 1'b0;
   logic off_req = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   logic busy0, done0, en0, sclk0, dat0;
   logic busy1, done1, en1, sclk1, dat1;

   panel_init_seq #(.HALF_CYC(H0), .ADDR_ENC(1'b0)) dut_i (
      .clk(clk), .rst(rst), .pwr_on_req(on_req), .pwr_off_req(off_req),
      .busy(busy0), .done(done0), .lcd_en_n(en0), .lcd_sclk(sclk0), .lcd_sdat(dat0));

   panel_init_seq #(.HALF_CYC(H1), .ADDR_ENC(1'b1)) dut_enc_i (
      .clk(clk), .rst(rst), .pwr_on_req(on_req), .pwr_off_req(off_req),
      .busy(busy1), .done(done1), .lcd_en_n(en1), .lcd_sclk(sclk1), .lcd_sdat(dat1));

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // expected per-cycle word {en_n, sclk, sdat, busy, done}
   logic [4:0] q0[$];
   logic [4:0] q1[$];

   logic [7:0] on_addr [12] = '{8'h05, 8'h05, 8'h0B, 8'h01, 8'h00, 8'h06,
                                8'h07, 8'h04, 8'h0D, 8'h10, 8'h11, 8'h05};
   logic [7:0] on_data [12] = '{8'h1E, 8'h5D, 8'h81, 8'h95, 8'h07, 8'h15,
                                8'h8D, 8'h0F, 8'h3D, 8'h42, 8'h3A, 8'h5F};

   task automatic push(input int d, input logic [4:0] v, input int n);
      for (int i = 0; i < n; i++) begin
         if (d == 0) q0.push_back(v);
         else        q1.push_back(v);
      end
   endtask

   task automatic gen_run(input int d, input bit pwr_on);
      int h = (d == 0) ? H0 : H1;
      int n = pwr_on ? 12 : 1;
      push(d, 5'b11010, 1);                       // accept cycle
      for (int f = 0; f < n; f++) begin
         logic [7:0]  a  = pwr_on ? on_addr[f] : 8'h05;
         logic [7:0]  v  = pwr_on ? on_data[f] : 8'h5E;
         logic [15:0] fr;
         int          gap = 4 + ((pwr_on && f == 0) ? 2 : 0) + ((d == 1) ? 4 : 0);
         if (d == 1) a = {a[5:0], 2'b10};         // R10
         fr = {a, v};
         push(d, 5'b01010, h);                    // setup, R3
         for (int b = 15; b >= 0; b--) begin
            push(d, {2'b00, fr[b], 2'b10}, h);    // R4 low half
            push(d, {2'b01, fr[b], 2'b10}, h);    // R4 high half
         end
         push(d, 5'b11010, gap * h);              // R6 gap
         if (f == n - 1) push(d, 5'b11001, 1);    // R9 done
         else            push(d, 5'b11010, 1);
      end
   endtask

   task automatic compare(input int d, input logic [4:0] act);
      logic [4:0] exp;
      string tag;
      if (d == 0) exp = (q0.size() != 0) ? q0.pop_front() : 5'b11000;
      else        exp = (q1.size() != 0) ? q1.pop_front() : 5'b11000;
      checks++;
      if (act !== exp) begin
         fails++;
         if      (act[0] !== exp[0]) tag = "R9 done";
         else if (act[1] !== exp[1]) tag = "R8 busy";
         else if (act[4] !== exp[4]) tag = "R3 R6 select";
         else if (act[3] !== exp[3]) tag = "R4 clock";
         else                        tag = "R2 R5 R7 R10 data";
         $display("FAIL %s dut%0d t=%0t actual=%b expected=%b", tag, d, $time, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (!rst && !finished) begin
            compare(0, {en0, sclk0, dat0, busy0, done0});
            compare(1, {en1, sclk1, dat1, busy1, done1});
         end
      end
   end

   task automatic wait_idle();
      while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_up();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      checks++;
      if ({en0, sclk0, dat0, busy0, done0, en1, sclk1, dat1, busy1, done1} !== 10'b1100011000) begin
         fails++;
         $display("FAIL R1 reset actual=%b%b%b%b%b expected=11000", en0, sclk0, dat0, busy0, done0);
      end
      rst = 1'b0;
      repeat (3) @(negedge clk);

      // R5 R6 power-on script, with R8 ignored requests while busy
      on_req = 1'b1; gen_run(0, 1'b1); gen_run(1, 1'b1);
      @(negedge clk); on_req = 1'b0;
      repeat (200) @(negedge clk);
      off_req = 1'b1; @(negedge clk); off_req = 1'b0;
      repeat (300) @(negedge clk);
      on_req = 1'b1; @(negedge clk); on_req = 1'b0;
      wait_idle();

      // R7 power-off write
      off_req = 1'b1; gen_run(0, 1'b0); gen_run(1, 1'b0);
      @(negedge clk); off_req = 1'b0;
      repeat (20) @(negedge clk);
      on_req = 1'b1; @(negedge clk); on_req = 1'b0;   // R8 ignored while busy
      wait_idle();

      // R8 both at once: power-on wins
      on_req = 1'b1; off_req = 1'b1; gen_run(0, 1'b1); gen_run(1, 1'b1);
      @(negedge clk); on_req = 1'b0; off_req = 1'b0;
      repeat (50) @(negedge clk);
      off_req = 1'b1; @(negedge clk); off_req = 1'b0;
      wait_idle();

      // second power-off after a full run
      off_req = 1'b1; gen_run(0, 1'b0); gen_run(1, 1'b0);
      @(negedge clk); off_req = 1'b0;
      wait_idle();

      finish_up();
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

endmodule